// File: doc/BRIEF.md
# Three-Stage Pipelined Converter Code Combiner

This block turns the raw decisions of a three-stage pipelined analog-to-digital converter into a single 12-bit sample. The first stage delivers a 3-bit coarse code and the second a 4-bit code. Each of these two codes carries half a bit of overlap so that small decision errors can be corrected. The last stage delivers a 7-bit binary fine code.

The stages resolve one sample at successive phases, so the three codes of one sample arrive on three separate strobes. The block holds each coarse code until the next stage's code for the same sample arrives. It then adds the three codes with overlapping binary weights (shifts of 9 and 6 bits), removes the constant offset of 288 that the overlap introduces, and clamps the result to 0..4095. The result is registered and flagged valid for one cycle. A coarse decision that lands one level off, because of comparator offset or residue gain error within the overlap range, is absorbed by the later stages. The word that comes out is then the exact ideal value.

Top module: `adc_corr_top`

## Requirements
- R1: While reset is asserted, and after it until the first output, `dout` is 0 and `dout_valid` is 0.
- R2: For an aligned set of codes D1 (3 bits), D2 (4 bits) and D3 (7 bits), `dout` equals D1*512 + D2*64 + D3 - 288, when that value lies within 0..4095.
- R3: `dout_valid` is high for exactly the one cycle after a cycle in which `s3_valid` is high and an aligned coarse pair is pending. It is low in every other cycle.
- R4: A stage-2 strobe pairs its code with the stage-1 code captured by an earlier strobe. A stage-3 strobe combines with the pair formed by an earlier stage-2 strobe. When a stage-1 and a stage-2 strobe coincide, or a stage-2 and a stage-3 strobe coincide, the later stage uses the older code, and the newer code is kept for the next sample.
- R5: Each pending code is used once. A stage-2 strobe with no pending stage-1 code is ignored. A stage-3 strobe with no pending pair produces no output and leaves `dout` unchanged.
- R6: When D1*512 + D2*64 + D3 is below 288, `dout` is 0.
- R7: When D1*512 + D2*64 + D3 - 288 exceeds 4095, `dout` is 4095.
- R8: The codes of an ideal quantiser are reconstructed exactly to the input value 0..4095. This holds when the stage-1 thresholds are shifted by less than 256 LSB and the stage-2 thresholds by less than 32 LSB, with the stage-1 residue offset by +256 and the stage-2 residue by +32.
- R9: Between output strobes, `dout` holds its last value regardless of the code inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s1_valid | input | 1 | Stage-1 code strobe |
| s1_code | input | 3 | Stage-1 coarse code |
| s2_valid | input | 1 | Stage-2 code strobe |
| s2_code | input | 4 | Stage-2 code |
| s3_valid | input | 1 | Stage-3 code strobe |
| s3_code | input | 7 | Stage-3 fine code |
| dout_valid | output | 1 | One-cycle pulse marking a new output word |
| dout | output | 12 | Corrected, clamped output word |

## Verification
The hardest case to reach from the ports is a coarse decision that is wrong but still inside the overlap. The later stage code must then swing to the edge of its range, and the sum must still land on the ideal value. The bench gets there with a behavioural three-stage quantiser. It sweeps the input across full scale and shifts the stage-1 and stage-2 thresholds by up to 255 and 31 LSB in both directions. It feeds the codes back-to-back, so that a stage-1 strobe of one sample coincides with the stage-3 strobe of the previous sample.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  // Default code widths of the three stages and of the output word.
  localparam int unsigned DEF_S1_W  = 3;
  localparam int unsigned DEF_S2_W  = 4;
  localparam int unsigned DEF_S3_W  = 7;
  localparam int unsigned DEF_OUT_W = 12;

  // Bit shift that weights a stage code: the next stages' width minus
  // the one overlap bit in each redundant stage.
  function automatic int unsigned stage_shift(input int unsigned w_next,
                                              input int unsigned shift_next);
    return shift_next + w_next - 1;
  endfunction
endpackage

// File: rtl/adc_corr_align.sv
module adc_corr_align #(
  parameter int unsigned S1_W = adc_corr_pkg::DEF_S1_W,
  parameter int unsigned S2_W = adc_corr_pkg::DEF_S2_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s1_valid,
  input  logic [S1_W-1:0] s1_code,
  input  logic            s2_valid,
  input  logic [S2_W-1:0] s2_code,
  input  logic            take,
  output logic            pair_vld,
  output logic [S1_W-1:0] pair_d1,
  output logic [S2_W-1:0] pair_d2
);
  logic            hold_vld_q, hold_vld_n;
  logic [S1_W-1:0] hold_q;
  logic            hold_en;
  logic            pair_vld_q, pair_vld_n;
  logic [S1_W-1:0] pd1_q;
  logic [S2_W-1:0] pd2_q;
  logic            pair_en;

  // Next-state logic
  always_comb begin
    pair_en    = s2_valid && hold_vld_q;
    hold_en    = s1_valid;
    hold_vld_n = hold_vld_q;
    if (s1_valid)     hold_vld_n = 1'b1;
    else if (pair_en) hold_vld_n = 1'b0;
    pair_vld_n = pair_vld_q;
    if (pair_en)      pair_vld_n = 1'b1;
    else if (take)    pair_vld_n = 1'b0;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld_q <= 1'b0;
      hold_q     <= '0;
      pair_vld_q <= 1'b0;
      pd1_q      <= '0;
      pd2_q      <= '0;
    end else begin
      hold_vld_q <= hold_vld_n;
      pair_vld_q <= pair_vld_n;
      if (hold_en) hold_q <= s1_code;
      if (pair_en) begin
        pd1_q <= hold_q;
        pd2_q <= s2_code;
      end
    end
  end

  assign pair_vld = pair_vld_q;
  assign pair_d1  = pd1_q;
  assign pair_d2  = pd2_q;

  AST_S2_TAKES_OLD_S1: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && hold_vld_q) |=> (pair_d1 == $past(hold_q)) && pair_vld) else $error("align"); // R4
  AST_ORPHAN_S2_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && !hold_vld_q) |=> $stable(pair_d2) && $stable(pair_d1)) else $error("orphan"); // R5
endmodule

// File: rtl/adc_corr_merge.sv
module adc_corr_merge #(
  parameter int unsigned S1_W  = adc_corr_pkg::DEF_S1_W,
  parameter int unsigned S2_W  = adc_corr_pkg::DEF_S2_W,
  parameter int unsigned S3_W  = adc_corr_pkg::DEF_S3_W,
  parameter int unsigned OUT_W = adc_corr_pkg::DEF_OUT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [S1_W-1:0]  d1,
  input  logic [S2_W-1:0]  d2,
  input  logic [S3_W-1:0]  d3,
  output logic             dout_valid,
  output logic [OUT_W-1:0] dout
);
  localparam int unsigned SH2   = adc_corr_pkg::stage_shift(S3_W, 0);
  localparam int unsigned SH1   = adc_corr_pkg::stage_shift(S2_W, SH2);
  localparam int unsigned OFFS  = (1 << (SH1 - 1)) + (1 << (SH2 - 1));
  localparam int unsigned SUM_W = SH1 + S1_W + 2;
  localparam int unsigned MAXV  = (1 << OUT_W) - 1;

  logic        [SUM_W-1:0] sum_u;
  logic signed [SUM_W-1:0] raw;
  logic        [OUT_W-1:0] sat_n;
  logic                    dv_q;
  logic        [OUT_W-1:0] dout_q;

  // Overlap-add, offset removal and clamp
  always_comb begin
    sum_u = (SUM_W'(d1) << SH1) + (SUM_W'(d2) << SH2) + SUM_W'(d3);
    raw   = $signed(sum_u) - $signed(SUM_W'(OFFS));
    if (raw < 0)
      sat_n = '0;
    else if (raw > $signed(SUM_W'(MAXV)))
      sat_n = OUT_W'(MAXV);
    else
      sat_n = raw[OUT_W-1:0];
  end

  // Output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      dv_q <= fire;
      if (fire) dout_q <= sat_n;
    end
  end

  assign dout_valid = dv_q;
  assign dout       = dout_q;

  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && raw < 0) |=> dout == '0) else $error("sat low"); // R6
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && raw > $signed(SUM_W'(MAXV))) |=> dout == OUT_W'(MAXV)) else $error("sat high"); // R7
  AST_VALID_AFTER_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> dout_valid) else $error("valid"); // R3
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !dout_valid) else $error("spurious"); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(dout)) else $error("hold"); // R9
endmodule

// File: rtl/adc_corr_top.sv
module adc_corr_top #(
  parameter int unsigned S1_W  = adc_corr_pkg::DEF_S1_W,
  parameter int unsigned S2_W  = adc_corr_pkg::DEF_S2_W,
  parameter int unsigned S3_W  = adc_corr_pkg::DEF_S3_W,
  parameter int unsigned OUT_W = adc_corr_pkg::DEF_OUT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s1_valid,
  input  logic [S1_W-1:0]  s1_code,
  input  logic             s2_valid,
  input  logic [S2_W-1:0]  s2_code,
  input  logic             s3_valid,
  input  logic [S3_W-1:0]  s3_code,
  output logic             dout_valid,
  output logic [OUT_W-1:0] dout
);
  logic            pair_vld;
  logic [S1_W-1:0] pair_d1;
  logic [S2_W-1:0] pair_d2;
  logic            fire;

  assign fire = s3_valid && pair_vld;

  adc_corr_align #(.S1_W(S1_W), .S2_W(S2_W)) u_align (
    .clk      (clk),
    .rst_n    (rst_n),
    .s1_valid (s1_valid),
    .s1_code  (s1_code),
    .s2_valid (s2_valid),
    .s2_code  (s2_code),
    .take     (s3_valid),
    .pair_vld (pair_vld),
    .pair_d1  (pair_d1),
    .pair_d2  (pair_d2)
  );

  adc_corr_merge #(.S1_W(S1_W), .S2_W(S2_W), .S3_W(S3_W), .OUT_W(OUT_W)) u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .d1         (pair_d1),
    .d2         (pair_d2),
    .d3         (s3_code),
    .dout_valid (dout_valid),
    .dout       (dout)
  );

  AST_NO_ORPHAN_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (s3_valid && !pair_vld) |=> (!dout_valid && $stable(dout))) else $error("orphan s3"); // R5
endmodule

// File: tb/adc_corr_top_test.sv
module adc_corr_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        s1_valid, s2_valid, s3_valid;
  logic [2:0]  s1_code;
  logic [3:0]  s2_code;
  logic [6:0]  s3_code;
  logic        dout_valid;
  logic [11:0] dout;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  adc_corr_top uut (
    .clk(clk), .rst_n(rst_n),
    .s1_valid(s1_valid), .s1_code(s1_code),
    .s2_valid(s2_valid), .s2_code(s2_code),
    .s3_valid(s3_valid), .s3_code(s3_code),
    .dout_valid(dout_valid), .dout(dout)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit v1, input int c1, input bit v2, input int c2,
                     input bit v3, input int c3);
    s1_valid = v1; s1_code = c1[2:0];
    s2_valid = v2; s2_code = c2[3:0];
    s3_valid = v3; s3_code = c3[6:0];
    @(posedge clk);
    #1;
  endtask

  task automatic run_one(input int d1, input int d2, input int d3, input int exp,
                         input string req);
    cyc(1, d1, 0, 0, 0, 0);
    cyc(0, 0, 1, d2, 0, 0);
    cyc(0, 0, 0, 0, 1, d3);
    chk({req, " valid"}, dout_valid, 1);
    chk({req, " value"}, dout, exp);
  endtask

  // Behavioural three-stage quantiser with threshold shifts
  task automatic quantise(input int x, input int dl1, input int dl2,
                          output int d1, output int d2, output int d3);
    int t, e1;
    t  = x + dl1;
    d1 = (t < 0) ? 0 : t / 512;
    if (d1 > 7) d1 = 7;
    e1 = x - 512 * d1 + 256;
    t  = e1 + dl2;
    d2 = (t < 0) ? 0 : t / 64;
    if (d2 > 15) d2 = 15;
    d3 = e1 - 64 * d2 + 32;
  endtask

  task automatic t_reset();
    chk("R1 valid in reset", dout_valid, 0);
    chk("R1 dout in reset", dout, 0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, 0);
    chk("R1 valid after release", dout_valid, 0);
    chk("R1 dout after release", dout, 0);
  endtask

  task automatic t_single();
    cyc(1, 3, 0, 0, 0, 0);
    chk("R3 no valid after s1", dout_valid, 0);
    cyc(0, 0, 1, 5, 0, 0);
    chk("R3 no valid after s2", dout_valid, 0);
    cyc(0, 0, 0, 0, 1, 40);
    chk("R3 valid after s3", dout_valid, 1);
    chk("R2 3/5/40", dout, 1608);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R3 valid one cycle only", dout_valid, 0);
    run_one(2, 7, 99, 1024 + 448 + 99 - 288, "R2 2/7/99");
  endtask

  task automatic t_saturate();
    run_one(0, 0, 100, 0, "R6 below offset");
    run_one(0, 4, 32, 0, "R6 exactly offset");
    run_one(0, 4, 33, 1, "R6 offset plus one");
    run_one(7, 15, 127, 4095, "R7 all ones");
    run_one(7, 12, 32, 4095, "R7 one over");
    run_one(7, 12, 31, 4095, "R7 exact max");
    run_one(7, 12, 30, 4094, "R7 below max");
  endtask

  task automatic t_orphan();
    cyc(0, 0, 0, 0, 1, 77);
    chk("R5 lone s3 valid", dout_valid, 0);
    chk("R5 lone s3 dout", dout, 4094);
    cyc(0, 0, 1, 9, 0, 0);
    cyc(0, 0, 0, 0, 1, 5);
    chk("R5 orphan s2 valid", dout_valid, 0);
    chk("R5 orphan s2 dout", dout, 4094);
    run_one(1, 1, 1, 512 + 64 + 1 - 288, "R5 fresh sample");
    cyc(0, 0, 0, 0, 1, 50);
    chk("R5 pair reused valid", dout_valid, 0);
    chk("R5 pair reused dout", dout, 289);
  endtask

  task automatic t_hold();
    run_one(2, 2, 2, 866, "R9 setup");
    for (int k = 0; k < 4; k++) begin
      cyc(0, k + 3, 0, k + 7, 0, k * 21);
      chk("R9 idle valid", dout_valid, 0);
      chk("R9 idle dout", dout, 866);
    end
  endtask

  task automatic t_overlap();
    cyc(1, 1, 0, 0, 0, 0);
    cyc(1, 6, 1, 3, 0, 0);
    chk("R4 s1+s2 no valid", dout_valid, 0);
    cyc(0, 0, 1, 9, 1, 10);
    chk("R4 s2+s3 valid", dout_valid, 1);
    chk("R4 s2+s3 uses older pair", dout, 426);
    cyc(0, 0, 0, 0, 1, 20);
    chk("R4 newer pair valid", dout_valid, 1);
    chk("R4 newer pair kept", dout, 3380);
  endtask

  task automatic t_sweep();
    int dl1_tab [5] = '{-255, -128, 0, 127, 255};
    int dl2_tab [5] = '{-31, -16, 0, 16, 31};
    int prev_x, prev_d3, x, d1, d2, d3;
    prev_x  = 0;
    prev_d3 = 0;
    for (int i = 0; i <= 111; i++) begin
      x = (i == 111) ? 4095 : i * 37;
      quantise(x, dl1_tab[i % 5], dl2_tab[(i * 3) % 5], d1, d2, d3);
      cyc(1, d1, 0, 0, i > 0, prev_d3);
      if (i > 0) begin
        chk("R8 sweep valid", dout_valid, 1);
        chk("R8 sweep value", dout, prev_x);
      end
      cyc(0, 0, 1, d2, 0, 0);
      if (i > 0) chk("R3 sweep gap", dout_valid, 0);
      prev_x  = x;
      prev_d3 = d3;
    end
    cyc(0, 0, 0, 0, 1, prev_d3);
    chk("R8 last valid", dout_valid, 1);
    chk("R8 full scale", dout, 4095);
    cyc(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    s1_valid = 0; s2_valid = 0; s3_valid = 0;
    s1_code = 0; s2_code = 0; s3_code = 0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_single();
    t_saturate();
    t_orphan();
    t_hold();
    t_overlap();
    t_sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule